// File: doc/BRIEF.md
# Interrupt latency measurement counter

This block counts how many clock cycles one interrupt request stays active. It watches a single IRQ line in the clock domain of the block. When a measurement ends, the count is placed in a latency register that a host can read. The host reaches the block through a small register port: a write strobe, an address and write data. Reads are combinational from the address.

Two detection variants are chosen by a parameter. In level mode, a one-flop delayed copy of the IRQ is XORed with the live line. The rising transition starts the count and the falling transition ends it. In pulse mode, the IRQ line drives the start directly and the host ends the measurement by writing a stop bit. While a measurement runs, further IRQ activity is ignored. Software clears the block with a reset bit before it takes a measurement.

Register map (word offsets):

| Offset | Access | Contents |
|--------|--------|----------|
| 0 | write-only, reads 0 | bit 0 = clear, bit 1 = stop |
| 1 | read-only | latency, zero-extended |
| 2 | read-only | bit 0 = counting, bit 1 = result valid |

Top module: `irq_latency_meter`

## Requirements
- R1: In level mode, the status counting bit (offset 2, bit 0) reads 1 right after the first rising clock edge at which the IRQ is sampled high while the block is idle.
- R2: In level mode, the latency register (offset 1) is loaded with N, the number of rising edges at which the IRQ was sampled high. The load happens at the first edge that samples the IRQ low. At that same edge the counting bit returns to 0.
- R3: The result valid bit (offset 2, bit 1) becomes 1 when the latency register is loaded. It stays 1 until a software clear.
- R4: Writing 1 to bit 0 of offset 0 clears the counter, the counting bit, the latency register and the valid bit. If this clear interrupts a running measurement, the IRQ falling edge that follows produces no result. A later measurement then works normally.
- R5: In level mode, writing the stop bit (offset 0, bit 1) has no effect on a running measurement.
- R6: In pulse mode, the IRQ sampled high while the block is idle starts a measurement. A write of bit 1 to offset 0, sampled D edges later, ends it. The latency register then reads D+1.
- R7: In pulse mode, further IRQ pulses, or an IRQ held high, during a measurement neither restart it nor reset it.
- R8: In pulse mode, a stop write while the block is idle leaves the latency register unchanged.
- R9: The counter saturates at 2^CNT_W-1 instead of wrapping. A result is therefore never larger than that value.
- R10: After hardware reset (rst_n low), the latency and status registers read 0.
- R11: During a new measurement, the latency register keeps the previous result. When the new measurement ends, its value replaces the old one.
- R12: Writes to offsets 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| irq | input | 1 | Interrupt request being measured, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word offset |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Read data for addr, combinational |

## Verification
Each result register changes at the clock edge that ends the measurement. It can be read through the combinational read path before the next edge. In level mode that edge is the first one that samples the IRQ low. In pulse mode it is the edge that samples the stop write. The bench drives every input just after a rising edge and keeps an exact count of the edges it spends. Each register check takes exactly one further edge and its value is compared at the following falling edge. The expected N or D+1 therefore includes the edges spent on mid-measurement status checks.

// File: rtl/irqlat_pkg.sv
`timescale 1ns/1ps
package irqlat_pkg;

   typedef enum logic {
      DET_LEVEL = 1'b0,
      DET_PULSE = 1'b1
   } det_mode_e;

   localparam int REG_CTRL = 0;
   localparam int REG_LAT  = 1;
   localparam int REG_STAT = 2;

   localparam int CTRL_CLR_BIT   = 0;
   localparam int CTRL_STOP_BIT  = 1;
   localparam int STAT_RUN_BIT   = 0;
   localparam int STAT_VALID_BIT = 1;

endpackage

// File: rtl/irqlat_detect.sv
`timescale 1ns/1ps
module irqlat_detect #(
   parameter irqlat_pkg::det_mode_e MODE = irqlat_pkg::DET_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq,
   output logic start_evt,
   output logic finish_evt
);

   generate
      if (MODE == irqlat_pkg::DET_LEVEL) begin : g_level
         logic irq_d;
         logic toggle;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_d <= 1'b0;
            else        irq_d <= irq;
         end

         assign toggle     = irq ^ irq_d;
         assign start_evt  = toggle & irq;
         assign finish_evt = toggle & ~irq;
      end else begin : g_pulse
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign start_evt  = irq;
         assign finish_evt = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/irqlat_counter.sv
`timescale 1ns/1ps
module irqlat_counter #(
   parameter int CNT_W   = 32,
   parameter bit ADD_ONE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_evt,
   input  logic             stop_evt,
   input  logic             sw_clr,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] lat,
   output logic             valid
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         cnt   <= '0;
         lat   <= '0;
         valid <= 1'b0;
      end else if (sw_clr) begin
         run   <= 1'b0;
         cnt   <= '0;
         lat   <= '0;
         valid <= 1'b0;
      end else if (run && stop_evt) begin
         run   <= 1'b0;
         lat   <= ADD_ONE ? cnt_inc : cnt;
         valid <= 1'b1;
      end else if (!run && start_evt) begin
         run <= 1'b1;
         cnt <= CNT_W'(1);
      end else if (run) begin
         cnt <= cnt_inc;
      end
   end

endmodule

// File: rtl/irqlat_regs.sv
`timescale 1ns/1ps
module irqlat_regs #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  lat,
   input  logic              run,
   input  logic              valid,
   output logic              sw_clr,
   output logic              stop_wr,
   output logic [DATA_W-1:0] rdata
);

   import irqlat_pkg::*;

   logic ctrl_sel;
   logic [1:0] stat_bits;
   logic unused_wdata;

   assign ctrl_sel = wr_en && (addr == ADDR_W'(REG_CTRL));
   assign sw_clr   = ctrl_sel && wdata[CTRL_CLR_BIT];
   assign stop_wr  = ctrl_sel && wdata[CTRL_STOP_BIT];
   assign unused_wdata = ^wdata;

   always_comb begin
      stat_bits = '0;
      stat_bits[STAT_RUN_BIT]   = run;
      stat_bits[STAT_VALID_BIT] = valid;
   end

   always_comb begin
      if (addr == ADDR_W'(REG_LAT))       rdata = DATA_W'(lat);
      else if (addr == ADDR_W'(REG_STAT)) rdata = DATA_W'(stat_bits);
      else                                rdata = '0;
   end

endmodule

// File: rtl/irq_latency_meter.sv
`timescale 1ns/1ps
module irq_latency_meter #(
   parameter int                    ADDR_W = 2,
   parameter int                    DATA_W = 32,
   parameter int                    CNT_W  = 32,
   parameter irqlat_pkg::det_mode_e MODE   = irqlat_pkg::DET_LEVEL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam bit PULSE_VAR = (MODE == irqlat_pkg::DET_PULSE);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("irq_latency_meter: CNT_W must be between 2 and DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("irq_latency_meter: ADDR_W must be at least 2");
      end
   endgenerate

   logic             start_w;
   logic             finish_w;
   logic             swclr_w;
   logic             stopwr_w;
   logic             stop_evt_w;
   logic             en_w;
   logic             valid_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] lat_w;

   irqlat_detect #(.MODE(MODE)) det_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq        (irq),
      .start_evt  (start_w),
      .finish_evt (finish_w)
   );

   generate
      if (PULSE_VAR) begin : g_stop_sw
         logic unused_finish;
         assign unused_finish = finish_w;
         assign stop_evt_w    = stopwr_w;
      end else begin : g_stop_edge
         logic unused_stop;
         assign unused_stop = stopwr_w;
         assign stop_evt_w  = finish_w;
      end
   endgenerate

   irqlat_counter #(.CNT_W(CNT_W), .ADD_ONE(PULSE_VAR)) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_evt (start_w),
      .stop_evt  (stop_evt_w),
      .sw_clr    (swclr_w),
      .run       (en_w),
      .cnt       (cnt_w),
      .lat       (lat_w),
      .valid     (valid_w)
   );

   irqlat_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .lat     (lat_w),
      .run     (en_w),
      .valid   (valid_w),
      .sw_clr  (swclr_w),
      .stop_wr (stopwr_w),
      .rdata   (rdata)
   );

endmodule

// File: rtl/irqlat_chk.sv
`timescale 1ns/1ps
module irqlat_chk #(
   parameter int                    ADDR_W = 2,
   parameter int                    CNT_W  = 32,
   parameter irqlat_pkg::det_mode_e MODE   = irqlat_pkg::DET_LEVEL
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        ctl,
   input logic              en,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  lat,
   input logic              valid
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic ctl_wr;
   logic clr_wr;
   logic stp_wr;

   assign ctl_wr = wr_en && (addr == ADDR_W'(irqlat_pkg::REG_CTRL));
   assign clr_wr = ctl_wr && ctl[0];
   assign stp_wr = ctl_wr && ctl[1];

   // R4: a software clear empties every result register
   a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (!en && !valid && lat == '0));

   // R3: the valid flag is held until a clear
   a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clr_wr) |=> valid);

   // R9: a saturated count does not wrap
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt == CMAX && !clr_wr) |=> (cnt == CMAX));

   generate
      if (MODE == irqlat_pkg::DET_LEVEL) begin : g_level_chk
         // R1: a rising IRQ starts counting
         a_r1_rise_starts: assert property (@(posedge clk) disable iff (!rst_n)
            (irq && !$past(irq) && !en && !clr_wr) |=> en);
         // R2: IRQ low during a measurement ends it with a result
         a_r2_fall_loads: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !irq && !clr_wr) |=> (!en && valid));
         // R5: the stop bit does not end a level measurement
         a_r5_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (en && irq && stp_wr && !clr_wr) |=> en);
      end else begin : g_pulse_chk
         // R6: a pulse while idle starts counting
         a_r6_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
            (!en && irq && !clr_wr) |=> en);
         // R6: the stop write ends the measurement with a result
         a_r6_stop_loads: assert property (@(posedge clk) disable iff (!rst_n)
            (en && stp_wr && !clr_wr) |=> (!en && valid));
         // R7: IRQ activity cannot end or restart a pulse measurement
         a_r7_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !stp_wr && !clr_wr) |=> (en && cnt != '0));
      end
   endgenerate

endmodule

bind irq_latency_meter irqlat_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE(MODE)) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .irq   (irq),
   .wr_en (wr_en),
   .addr  (addr),
   .ctl   (wdata[1:0]),
   .en    (en_w),
   .cnt   (cnt_w),
   .lat   (lat_w),
   .valid (valid_w)
);

// File: tb/irq_latency_meter_tb_top.sv
`timescale 1ns/1ps
module irq_latency_meter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_l = 1'b0;
   logic        irq_p = 1'b0;
   logic        wr_l = 1'b0;
   logic        wr_p = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata_l;
   logic [31:0] rdata_p;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   bit          sel_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_LAT  = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;

   always #5 clk = ~clk;

   irq_latency_meter #(.MODE(irqlat_pkg::DET_LEVEL)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq(irq_l), .wr_en(wr_l),
      .addr(addr), .wdata(wdata), .rdata(rdata_l)
   );

   irq_latency_meter #(.CNT_W(4), .MODE(irqlat_pkg::DET_PULSE)) dut_p (
      .clk(clk), .rst_n(rst_n), .irq(irq_p), .wr_en(wr_p),
      .addr(addr), .wdata(wdata), .rdata(rdata_p)
   );

   // monitor: pops expected items and compares against the live read data
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            bit          s;
            logic [31:0] e;
            logic [31:0] got;
            string       t;
            s = sel_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = s ? rdata_p : rdata_l;
            checks++;
            if (got !== e) begin
               errors++;
               $display("FAIL %s: actual=%0d expected=%0d", t, got, e);
            end
         end
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(input bit sel, input logic [1:0] a, input logic [31:0] d);
      addr  = a;
      wdata = d;
      if (sel) wr_p = 1'b1;
      else     wr_l = 1'b1;
      tick(1);
      wr_l  = 1'b0;
      wr_p  = 1'b0;
      wdata = 32'd0;
   endtask

   // driver: queue one expected read, spend exactly one clock edge
   task automatic chk(input bit sel, input logic [1:0] a, input logic [31:0] e, input string t);
      addr = a;
      sel_q.push_back(sel);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      #1;
      @(posedge clk);
      #1;
   endtask

   task automatic pulse_run(input int d);
      irq_p = 1'b1;
      tick(1);
      irq_p = 1'b0;
      tick(d - 1);
      wr(1'b1, A_CTRL, 32'd2);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R10: reset state
      chk(1'b0, A_LAT,  32'd0, "R10 level latency");
      chk(1'b0, A_STAT, 32'd0, "R10 level status");
      chk(1'b1, A_STAT, 32'd0, "R10 pulse status");

      // R1 R2 R3: five sampled-high edges
      irq_l = 1'b1;
      tick(1);
      chk(1'b0, A_STAT, 32'd1, "R1 counting set");
      tick(3);
      irq_l = 1'b0;
      tick(1);
      chk(1'b0, A_LAT,  32'd5, "R2 latency five");
      chk(1'b0, A_STAT, 32'd2, "R3 valid set");

      // R11: previous result held, then replaced (seven edges)
      irq_l = 1'b1;
      tick(1);
      chk(1'b0, A_LAT,  32'd5, "R11 held latency");
      chk(1'b0, A_STAT, 32'd3, "R11 valid and counting");
      tick(4);
      irq_l = 1'b0;
      tick(1);
      chk(1'b0, A_LAT,  32'd7, "R11 new latency");

      // R5: stop write during a level measurement (three edges)
      irq_l = 1'b1;
      tick(1);
      wr(1'b0, A_CTRL, 32'd2);
      tick(1);
      irq_l = 1'b0;
      tick(1);
      chk(1'b0, A_LAT,  32'd3, "R5 stop ignored");

      // R12: writes to read-only offsets
      wr(1'b0, A_LAT,  32'hFFFF_FFFF);
      wr(1'b0, A_STAT, 32'hFFFF_FFFF);
      chk(1'b0, A_LAT,  32'd3, "R12 latency unchanged");
      chk(1'b0, A_STAT, 32'd2, "R12 status unchanged");

      // R4: clear in mid-measurement, following fall gives no result
      irq_l = 1'b1;
      tick(3);
      wr(1'b0, A_CTRL, 32'd1);
      chk(1'b0, A_STAT, 32'd0, "R4 cleared while irq high");
      irq_l = 1'b0;
      tick(2);
      chk(1'b0, A_LAT,  32'd0, "R4 no result after fall");
      chk(1'b0, A_STAT, 32'd0, "R4 status after fall");
      irq_l = 1'b1;
      tick(2);
      irq_l = 1'b0;
      tick(1);
      chk(1'b0, A_LAT,  32'd2, "R4 fresh measurement");

      // R6: pulse, stop write three edges later
      irq_p = 1'b1;
      tick(1);
      irq_p = 1'b0;
      chk(1'b1, A_STAT, 32'd1, "R6 counting after pulse");
      tick(1);
      wr(1'b1, A_CTRL, 32'd2);
      chk(1'b1, A_LAT,  32'd4, "R6 latency D+1");
      chk(1'b1, A_STAT, 32'd2, "R6 status");

      // R8: stop while idle
      wr(1'b1, A_CTRL, 32'd2);
      chk(1'b1, A_LAT,  32'd4, "R8 idle stop");

      // R7: second pulse during measurement, D = 5
      irq_p = 1'b1;
      tick(1);
      irq_p = 1'b0;
      tick(2);
      irq_p = 1'b1;
      tick(1);
      irq_p = 1'b0;
      chk(1'b1, A_STAT, 32'd3, "R7 still counting");
      wr(1'b1, A_CTRL, 32'd2);
      chk(1'b1, A_LAT,  32'd6, "R7 extra pulse ignored");

      // R7: irq held high, D = 4
      irq_p = 1'b1;
      tick(4);
      irq_p = 1'b0;
      wr(1'b1, A_CTRL, 32'd2);
      chk(1'b1, A_LAT,  32'd5, "R7 held irq ignored");

      // R9: saturation at 15 for a 4-bit counter
      pulse_run(13);
      chk(1'b1, A_LAT,  32'd14, "R9 below limit");
      pulse_run(14);
      chk(1'b1, A_LAT,  32'd15, "R9 at limit");
      pulse_run(20);
      chk(1'b1, A_LAT,  32'd15, "R9 saturated");

      // R4: clear in pulse variant
      wr(1'b1, A_CTRL, 32'd1);
      chk(1'b1, A_LAT,  32'd0, "R4 pulse latency cleared");
      chk(1'b1, A_STAT, 32'd0, "R4 pulse status cleared");

      tick(2);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule